// File: doc/BRIEF.md
# MSI Doorbell Interrupt Frame

This block turns message-signalled interrupts into pulses on dedicated interrupt lines. It sits on a simple 32-bit register bus and decodes a 4 KiB window. A device raises an interrupt by writing an interrupt ID to the doorbell register. When the ID falls inside the range assigned to this frame, the matching output line pulses high for one clock cycle. When the ID falls outside that range, the write is dropped without any effect.

Software finds the assigned ID range by reading a type register. It identifies the frame by reading an identity register. Two parameters set the first line's ID offset and the number of lines. Elaboration rejects any combination that breaks the ID space limits. Every request gets a response one cycle later. Accesses with a bad size or an unknown offset return zero and raise a one-cycle error flag.

Top module: `msi_doorbell_frame`

## Requirements
- R1: A 32-bit read at offset 0x008 returns the absolute first interrupt ID (BASE_OFS + 32) in bits [31:16] and LINE_CNT in bits [15:0], with no error.
- R2: A 32-bit read at offset 0xFCC returns 0x0510_0000 (product code 0x51 at bit 20, all other fields zero), with no error.
- R3: A write at offset 0x040 whose write data bits [9:0] hold an ID in the range [BASE_OFS+32, BASE_OFS+32+LINE_CNT) drives irq_pulse[ID-(BASE_OFS+32)] high for exactly the one cycle after the request. No other line goes high, and write data bits [31:10] are ignored.
- R4: A doorbell write whose ID lies outside that range drives no line and raises no error.
- R5: Doorbell writes on consecutive cycles each produce a pulse in the cycle that follows them, even when they target the same line.
- R6: A 32-bit read anywhere in offsets 0xFD0 to 0xFFC returns zero with no error.
- R7: req_size encodes the access width: 0 = 8-bit, 1 = 16-bit, 2 = 32-bit, 3 = 64-bit. A read of any size other than 32-bit returns zero and raises rsp_err.
- R8: Only 16-bit and 32-bit writes are accepted. Any other write size raises rsp_err and pulses no line, even with a valid doorbell ID.
- R9: A read from any offset not listed in R1, R2 or R6 returns zero and raises rsp_err. This includes 0x040. A write to any offset other than 0x040 pulses no line and raises rsp_err. This includes 0x008.
- R10: rsp_valid is high in exactly the cycle after each request. rsp_err is a single-cycle flag aligned with rsp_valid, and rsp_rdata is zero whenever rsp_err is high.
- R11: During and right after reset, rsp_valid, rsp_err, rsp_rdata and irq_pulse are all zero.
- R12: Elaboration fails unless LINE_CNT is between 1 and 128 and BASE_OFS + 32 + LINE_CNT does not exceed 1020.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset within the 4 KiB window |
| req_wdata | input | 32 | Write data, little-endian |
| req_size | input | 2 | Access size code (see R7) |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_rdata | output | 32 | Read data, zero for writes and errors |
| rsp_err | output | 1 | Bad size or bad offset on the previous request |
| irq_pulse | output | LINE_CNT | One-cycle pulse per accepted doorbell |

## Verification
The bench tests doorbell translation with several kinds of ID:
- IDs well inside the range, and the first and last IDs of the range, which expose off-by-one errors in the subtraction and in the limit compare.
- IDs just below and just above the range, and the all-ones ID, which separate a dropped doorbell from a flagged one.
- A doorbell whose upper data bits are all set, which shows that only the 10-bit field is decoded.

Back-to-back doorbells to the same line and to different lines show whether each request is handled on its own rather than merged. Doorbells of every access size, and reads and writes to the wrong registers, separate size checking from offset checking.

// File: rtl/msi_frame_pkg.sv
package msi_frame_pkg;

  localparam int unsigned ADDR_W    = 12;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned ID_W      = 10;
  localparam int unsigned ID_SKEW   = 32;
  localparam int unsigned ID_LIMIT  = 1020;
  localparam int unsigned MAX_LINES = 128;

  localparam logic [ADDR_W-1:0] OFS_TYPE     = 12'h008;
  localparam logic [ADDR_W-1:0] OFS_DOORBELL = 12'h040;
  localparam logic [ADDR_W-1:0] OFS_IDENT    = 12'hFCC;
  localparam logic [ADDR_W-1:0] OFS_IMPL_LO  = 12'hFD0;
  localparam logic [ADDR_W-1:0] OFS_IMPL_HI  = 12'hFFC;

  localparam logic [DATA_W-1:0] IDENT_WORD = 32'h51 << 20;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_DWORD = 2'd3
  } acc_size_e;

  typedef struct packed {
    logic              err;
    logic              ring;
    logic [DATA_W-1:0] rdata;
  } dec_result_t;

endpackage

// File: rtl/msi_reg_decode.sv
module msi_reg_decode
  import msi_frame_pkg::*;
#(
  parameter int unsigned FIRST_ID = 32,
  parameter int unsigned LINE_CNT = 64
) (
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  output dec_result_t       result
);

  localparam logic [DATA_W-1:0] TYPE_WORD = {16'(FIRST_ID), 16'(LINE_CNT)};

  logic size_word;
  logic wr_size_ok;
  logic in_impl;

  always_comb begin
    size_word  = (req_size == SZ_WORD);
    wr_size_ok = (req_size == SZ_HALF) || (req_size == SZ_WORD);
    in_impl    = (req_addr >= OFS_IMPL_LO) && (req_addr <= OFS_IMPL_HI);
    result     = '0;
    if (req_valid) begin
      if (req_write) begin
        if ((req_addr == OFS_DOORBELL) && wr_size_ok) result.ring = 1'b1;
        else                                           result.err  = 1'b1;
      end else if (!size_word) begin
        result.err = 1'b1;
      end else if (req_addr == OFS_TYPE) begin
        result.rdata = TYPE_WORD;
      end else if (req_addr == OFS_IDENT) begin
        result.rdata = IDENT_WORD;
      end else if (!in_impl) begin
        result.err = 1'b1;
      end
    end
  end

endmodule

// File: rtl/msi_id_xlate.sv
module msi_id_xlate
  import msi_frame_pkg::*;
#(
  parameter int unsigned FIRST_ID = 32,
  parameter int unsigned LINE_CNT = 64,
  parameter int unsigned IDX_W    = 6
) (
  input  logic              ring,
  input  logic [DATA_W-1:0] wdata,
  output logic              hit,
  output logic [IDX_W-1:0]  idx
);

  localparam logic [ID_W:0] FIRST_EXT = (ID_W+1)'(FIRST_ID);
  localparam logic [ID_W:0] CNT_EXT   = (ID_W+1)'(LINE_CNT);

  logic [ID_W:0] diff;
  logic          unused_hi;

  assign unused_hi = ^wdata[DATA_W-1:ID_W];

  always_comb begin
    diff = {1'b0, wdata[ID_W-1:0]} - FIRST_EXT;
    hit  = ring && !diff[ID_W] && (diff < CNT_EXT);
    idx  = diff[IDX_W-1:0];
  end

endmodule

// File: rtl/msi_pulse_gen.sv
module msi_pulse_gen #(
  parameter int unsigned LINE_CNT = 64,
  parameter int unsigned IDX_W    = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hit,
  input  logic [IDX_W-1:0]    idx,
  output logic [LINE_CNT-1:0] irq_pulse
);

  logic [LINE_CNT-1:0] pulse_d;
  logic [LINE_CNT-1:0] pulse_q;

  for (genvar i = 0; i < LINE_CNT; i++) begin : g_line
    always_comb pulse_d[i] = hit && (idx == IDX_W'(i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= '0;
    else        pulse_q <= pulse_d;
  end

  assign irq_pulse = pulse_q;

  assert_single_line_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_pulse));

  assert_pulse_ends_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_pulse && !hit) |=> (irq_pulse == '0));

endmodule

// File: rtl/msi_doorbell_frame.sv
module msi_doorbell_frame
  import msi_frame_pkg::*;
#(
  parameter int unsigned BASE_OFS = 0,
  parameter int unsigned LINE_CNT = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [11:0]         req_addr,
  input  logic [31:0]         req_wdata,
  input  logic [1:0]          req_size,
  output logic                rsp_valid,
  output logic [31:0]         rsp_rdata,
  output logic                rsp_err,
  output logic [LINE_CNT-1:0] irq_pulse
);

  localparam int unsigned FIRST_ID = BASE_OFS + ID_SKEW;
  localparam int unsigned IDX_W    = (LINE_CNT > 1) ? $clog2(LINE_CNT) : 1;

  // R12: parameter legality checked at elaboration
  if (LINE_CNT < 1 || LINE_CNT > MAX_LINES) begin : g_bad_count
    $error("msi_doorbell_frame: LINE_CNT out of range");
  end
  if (FIRST_ID + LINE_CNT > ID_LIMIT) begin : g_bad_base
    $error("msi_doorbell_frame: ID range exceeds limit");
  end

  dec_result_t       dec;
  logic              hit;
  logic [IDX_W-1:0]  idx;

  msi_reg_decode #(.FIRST_ID(FIRST_ID), .LINE_CNT(LINE_CNT)) i_decode (
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_size  (req_size),
    .result    (dec)
  );

  msi_id_xlate #(.FIRST_ID(FIRST_ID), .LINE_CNT(LINE_CNT), .IDX_W(IDX_W)) i_xlate (
    .ring  (dec.ring),
    .wdata (req_wdata),
    .hit   (hit),
    .idx   (idx)
  );

  msi_pulse_gen #(.LINE_CNT(LINE_CNT), .IDX_W(IDX_W)) i_pulse (
    .clk       (clk),
    .rst_n     (rst_n),
    .hit       (hit),
    .idx       (idx),
    .irq_pulse (irq_pulse)
  );

  // response stage
  logic        valid_d, valid_q;
  logic        err_d,   err_q;
  logic [31:0] rdata_d, rdata_q;
  logic        rdata_en;

  always_comb begin
    valid_d  = req_valid;
    err_d    = dec.err;
    rdata_en = req_valid || valid_q;
    rdata_d  = dec.err ? '0 : dec.rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      err_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      valid_q <= valid_d;
      err_q   <= err_d;
      if (rdata_en) rdata_q <= rdata_d;
    end
  end

  assign rsp_valid = valid_q;
  assign rsp_err   = err_q;
  assign rsp_rdata = rdata_q;

  assert_rsp_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  assert_no_spurious_rsp_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  assert_err_with_rsp_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (rsp_valid && rsp_rdata == '0));

  assert_pulse_needs_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_pulse) |-> $past(req_valid && req_write && req_addr == OFS_DOORBELL));

  assert_no_pulse_on_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> (irq_pulse == '0));

  assert_pulse_no_err_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_pulse) |-> !rsp_err);

endmodule

// File: tb/test_msi_doorbell_frame.sv
`timescale 1ns/1ps
module test_msi_doorbell_frame;

  localparam int unsigned LINES = 64;
  localparam int unsigned FIRST = 32;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             req_valid, req_write;
  logic [11:0]      req_addr;
  logic [31:0]      req_wdata;
  logic [1:0]       req_size;
  logic             rsp_valid, rsp_err;
  logic [31:0]      rsp_rdata;
  logic [LINES-1:0] irq_pulse;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;

  msi_doorbell_frame #(.BASE_OFS(0), .LINE_CNT(LINES)) i_msi_doorbell_frame (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_size(req_size),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .irq_pulse(irq_pulse)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // drive one cycle of request (or idle) at a falling edge, land on the next falling edge
  task automatic step(input logic v, input logic w, input logic [11:0] a,
                      input logic [31:0] d, input logic [1:0] s);
    req_valid = v; req_write = w; req_addr = a; req_wdata = d; req_size = s;
    @(negedge clk);
  endtask

  task automatic idle();
    step(1'b0, 1'b0, 12'h0, 32'h0, 2'd0);
  endtask

  function automatic logic [63:0] line(input int i);
    return 64'h1 << i;
  endfunction

  task automatic t_reset();
    chk("R11 rsp_valid in reset", 64'(rsp_valid), 64'h0);
    chk("R11 rsp_err in reset",   64'(rsp_err),   64'h0);
    chk("R11 rsp_rdata in reset", 64'(rsp_rdata), 64'h0);
    chk("R11 irq_pulse in reset", irq_pulse,      64'h0);
  endtask

  task automatic t_ident_regs();
    step(1, 0, 12'h008, 0, 2'd2);
    chk("R1 type word", 64'(rsp_rdata), 64'h0020_0040);
    chk("R1 type no err", 64'(rsp_err), 64'h0);
    // R12: advertised range stays inside the ID limit
    chk("R12 range within limit", 64'((rsp_rdata[31:16] + rsp_rdata[15:0]) <= 1020), 64'h1);
    step(1, 0, 12'hFCC, 0, 2'd2);
    chk("R2 ident word", 64'(rsp_rdata), 64'h0510_0000);
    chk("R2 ident no err", 64'(rsp_err), 64'h0);
    idle();
  endtask

  task automatic t_impl_zero();
    step(1, 0, 12'h008, 0, 2'd2);          // load non-zero data first
    step(1, 0, 12'hFD0, 0, 2'd2);
    chk("R6 0xFD0 data", 64'(rsp_rdata), 64'h0);
    chk("R6 0xFD0 err",  64'(rsp_err),   64'h0);
    step(1, 0, 12'hFE8, 0, 2'd2);
    chk("R6 0xFE8 data", 64'(rsp_rdata), 64'h0);
    step(1, 0, 12'hFFC, 0, 2'd2);
    chk("R6 0xFFC err",  64'(rsp_err),   64'h0);
    chk("R6 0xFFC valid", 64'(rsp_valid), 64'h1);
    idle();
  endtask

  task automatic t_doorbell();
    step(1, 1, 12'h040, 32'd40, 2'd2);
    chk("R3 id 40 -> line 8", irq_pulse, line(8));
    chk("R3 doorbell no err", 64'(rsp_err), 64'h0);
    idle();
    chk("R3 pulse one cycle", irq_pulse, 64'h0);
    step(1, 1, 12'h040, FIRST, 2'd2);
    chk("R3 first id -> line 0", irq_pulse, line(0));
    step(1, 1, 12'h040, FIRST + LINES - 1, 2'd2);
    chk("R3 last id -> line 63", irq_pulse, line(63));
    step(1, 1, 12'h040, 32'hFFFF_FC00 | 32'd50, 2'd2);
    chk("R3 upper bits ignored -> line 18", irq_pulse, line(18));
    step(1, 1, 12'h040, 32'd70, 2'd1);
    chk("R8 16-bit doorbell -> line 38", irq_pulse, line(38));
    idle();
  endtask

  task automatic t_out_of_range();
    step(1, 1, 12'h040, FIRST + LINES, 2'd2);
    chk("R4 id above range no pulse", irq_pulse, 64'h0);
    chk("R4 id above range no err", 64'(rsp_err), 64'h0);
    step(1, 1, 12'h040, FIRST - 1, 2'd2);
    chk("R4 id below range no pulse", irq_pulse, 64'h0);
    step(1, 1, 12'h040, 32'h3FF, 2'd2);
    chk("R4 id 0x3FF no pulse", irq_pulse, 64'h0);
    chk("R4 id 0x3FF no err", 64'(rsp_err), 64'h0);
    idle();
  endtask

  task automatic t_back_to_back();
    step(1, 1, 12'h040, 32'd33, 2'd2);
    chk("R5 first pulse line 1", irq_pulse, line(1));
    step(1, 1, 12'h040, 32'd33, 2'd2);
    chk("R5 repeat pulse line 1", irq_pulse, line(1));
    step(1, 1, 12'h040, 32'd34, 2'd2);
    chk("R5 next pulse line 2", irq_pulse, line(2));
    idle();
    chk("R5 idle after burst", irq_pulse, 64'h0);
  endtask

  task automatic t_bad_sizes();
    step(1, 0, 12'h008, 0, 2'd1);
    chk("R7 half read data", 64'(rsp_rdata), 64'h0);
    chk("R7 half read err",  64'(rsp_err),   64'h1);
    step(1, 0, 12'hFCC, 0, 2'd0);
    chk("R7 byte read err",  64'(rsp_err),   64'h1);
    step(1, 0, 12'h008, 0, 2'd3);
    chk("R7 dword read data", 64'(rsp_rdata), 64'h0);
    step(1, 1, 12'h040, 32'd40, 2'd0);
    chk("R8 byte write no pulse", irq_pulse, 64'h0);
    chk("R8 byte write err", 64'(rsp_err), 64'h1);
    step(1, 1, 12'h040, 32'd40, 2'd3);
    chk("R8 dword write no pulse", irq_pulse, 64'h0);
    chk("R8 dword write err", 64'(rsp_err), 64'h1);
    idle();
    chk("R10 err single cycle", 64'(rsp_err), 64'h0);
  endtask

  task automatic t_bad_offsets();
    step(1, 0, 12'h040, 0, 2'd2);
    chk("R9 read doorbell err", 64'(rsp_err), 64'h1);
    chk("R9 read doorbell data", 64'(rsp_rdata), 64'h0);
    step(1, 1, 12'h008, 32'd40, 2'd2);
    chk("R9 write type reg no pulse", irq_pulse, 64'h0);
    chk("R9 write type reg err", 64'(rsp_err), 64'h1);
    step(1, 0, 12'h004, 0, 2'd2);
    chk("R9 read 0x004 err", 64'(rsp_err), 64'h1);
    step(1, 0, 12'hFC8, 0, 2'd2);
    chk("R9 read 0xFC8 err", 64'(rsp_err), 64'h1);
    step(1, 1, 12'hFD0, 32'd40, 2'd2);
    chk("R9 write 0xFD0 err", 64'(rsp_err), 64'h1);
    chk("R9 write 0xFD0 no pulse", irq_pulse, 64'h0);
    step(1, 1, 12'h044, 32'd40, 2'd2);
    chk("R9 write 0x044 no pulse", irq_pulse, 64'h0);
    idle();
  endtask

  task automatic t_timing();
    step(1, 0, 12'h008, 0, 2'd2);
    chk("R10 valid after request", 64'(rsp_valid), 64'h1);
    idle();
    chk("R10 valid drops when idle", 64'(rsp_valid), 64'h0);
    chk("R10 err low when idle", 64'(rsp_err), 64'h0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL R10 watchdog: actual hung expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0; req_size = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ident_regs();
    t_impl_zero();
    t_doorbell();
    t_out_of_range();
    t_back_to_back();
    t_bad_sizes();
    t_bad_offsets();
    t_timing();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

endmodule